// File: doc/BRIEF.md
# Programmable Window Watchdog Supervisor

This block supervises an external microcontroller. After power-up it stays dormant until software writes an arming strobe. From that point it counts time in units of a base tick. Each acknowledge strobe from the controller restarts the count. If the count reaches the programmed limit first, the block pulls a shared active-low reset/watchdog pin low for a fixed number of cycles. It then drops back to the dormant state, and software must arm it again.

The limit comes from a 4-bit code. The code is captured each time the count restarts, so a new code takes effect only at the next arm or acknowledge. The power-on condition is an asynchronous active-low input. While that input is low, and for a fixed pulse after it rises, the shared pin is held low. A synchronous hard-clear input takes the block to the dormant state at once and never drives the pin low.

Top module: `wd_supervisor`

## Requirements
- R1: While rstN is low, wdPinN is 0 and armed is 0. After rstN rises, wdPinN returns to 1 at the PULSE_CYCLES-th rising clock edge (16 by default).
- R2: After power-on, and with no arming strobe, wdPinN stays 1 indefinitely.
- R3: If armStb is sampled high at edge k while the block is dormant, armed is 1 from that edge. With code c captured at edge k, wdPinN falls at edge k+(c+1)*BASE_CYCLES (BASE_CYCLES is 32 by default).
- R4: If ackStb is sampled high at edge j while armed, the count restarts and wdPinN falls at edge j+(c'+1)*BASE_CYCLES, where c' is the code at edge j. An acknowledge at the very edge the limit is reached wins over the timeout.
- R5: A timeout holds wdPinN at 0 for exactly PULSE_CYCLES cycles.
- R6: At the edge where wdPinN falls on a timeout, armed becomes 0. No further pulse occurs until the block is armed again.
- R7: ackStb has no effect while the block is not armed. It does not arm the block and causes no pulse.
- R8: Changing wdtCode while armed does not alter the running limit. The limit uses the code captured at the last arm or acknowledge.
- R9: hardClr sampled high makes armed 0 and wdPinN 1 from that edge, including during a pulse. While hardClr is high, wdPinN is never driven low and armStb/ackStb are ignored.
- R10: armStb during a timeout pulse is ignored. armed is 0 after the pulse ends, and no new pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low power-on condition |
| hardClr | input | 1 | Synchronous hard clear, active high |
| armStb | input | 1 | One-cycle strobe: enable bit written to 1 |
| ackStb | input | 1 | One-cycle acknowledge strobe |
| wdtCode | input | 4 | Timeout code c; limit is (c+1) base ticks |
| wdPinN | output | 1 | Shared active-low reset/watchdog pin |
| armed | output | 1 | Status flag: watchdog enabled and counting |

## Verification
The timeout path is driven with random codes, arm times and acknowledge offsets. Some runs have no acknowledge, which measures the raw limit. Others acknowledge at a random point, which shows that the count restarts rather than continues. A code change made at the same moment as an acknowledge, or without any acknowledge, separates capture-at-restart from live use of the code. Directed cases place an acknowledge on the exact expiry edge, a hard clear in mid-count and in mid-pulse, arming during a pulse, and acknowledges while dormant. These expose wrong priorities between the competing strobes.

// File: rtl/wd_pkg.sv
package wd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PULSE = 2'd2
  } wdState_t;

  typedef struct packed {
    logic restart;   // zero counters, capture code
    logic clear;     // zero counters
    logic count;     // advance timeout counters
    logic pulseLoad; // load pulse length
    logic pulseRun;  // advance pulse counter
  } wdCtl_t;

endpackage

// File: rtl/wd_datapath.sv
module wd_datapath
  import wd_pkg::*;
#(
  parameter int BASE_CYCLES  = 32,
  parameter int PULSE_CYCLES = 16,
  parameter int CODE_W       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdCtl_t            ctl,
  input  logic [CODE_W-1:0] wdtCode,
  output logic              expire,
  output logic              pulseDone
);

  localparam int PRE_W   = (BASE_CYCLES > 1) ? $clog2(BASE_CYCLES) : 1;
  localparam int PULSE_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [PRE_W-1:0]   PRE_LAST   = PRE_W'(BASE_CYCLES - 1);
  localparam logic [PULSE_W-1:0] PULSE_LAST = PULSE_W'(PULSE_CYCLES - 1);

  logic [PRE_W-1:0]   preCnt;
  logic [CODE_W-1:0]  tickCnt;
  logic [CODE_W-1:0]  wdtLatched;
  logic [PULSE_W-1:0] pulseCnt;
  logic               tick;

  assign tick   = ctl.count && (preCnt == PRE_LAST);
  assign expire = tick && (tickCnt == wdtLatched);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt     <= '0;
      tickCnt    <= '0;
      wdtLatched <= '0;
    end else if (ctl.restart) begin
      preCnt     <= '0;
      tickCnt    <= '0;
      wdtLatched <= wdtCode;
    end else if (ctl.clear) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (ctl.count) begin
      if (tick) begin
        preCnt  <= '0;
        tickCnt <= expire ? '0 : tickCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assign pulseDone = (pulseCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pulseCnt <= PULSE_LAST;
    else if (ctl.pulseLoad)
      pulseCnt <= PULSE_LAST;
    else if (ctl.clear)
      pulseCnt <= '0;
    else if (ctl.pulseRun && !pulseDone)
      pulseCnt <= pulseCnt - 1'b1;
  end

  // R3
  tick_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= wdtLatched);

  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.restart |=> $stable(wdtLatched));

  // R5
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= PULSE_LAST);

endmodule

// File: rtl/wd_control.sv
module wd_control
  import wd_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   hardClr,
  input  logic   armStb,
  input  logic   ackStb,
  input  logic   expire,
  input  logic   pulseDone,
  output wdCtl_t ctl,
  output logic   wdPinN,
  output logic   armed
);

  wdState_t state, nextState;

  always_comb begin
    ctl       = '0;
    nextState = state;
    if (hardClr) begin
      ctl.clear = 1'b1;
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (armStb) begin
            ctl.restart = 1'b1;
            nextState   = ST_RUN;
          end
        end
        ST_RUN: begin
          ctl.count = 1'b1;
          if (ackStb) begin
            ctl.restart = 1'b1;
          end else if (expire) begin
            ctl.pulseLoad = 1'b1;
            nextState     = ST_PULSE;
          end
        end
        ST_PULSE: begin
          ctl.pulseRun = 1'b1;
          if (pulseDone) nextState = ST_IDLE;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_PULSE;
      wdPinN <= 1'b0;
    end else begin
      state  <= nextState;
      wdPinN <= (nextState != ST_PULSE);
    end
  end

  assign armed = (state == ST_RUN);

  // R9
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    hardClr |=> (wdPinN && !armed));

  // R6
  fire_from_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdPinN) |-> ($past(armed) && !armed));

  // R7
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && wdPinN && ackStb && !armStb && !hardClr) |=> !armed);

  // R5
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PULSE && !pulseDone && !hardClr) |=> !wdPinN);

  // R10
  pulse_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PULSE) |=> !armed);

endmodule

// File: rtl/wd_supervisor.sv
module wd_supervisor
  import wd_pkg::*;
#(
  parameter int BASE_CYCLES  = 32,
  parameter int PULSE_CYCLES = 16,
  parameter int CODE_W       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hardClr,
  input  logic              armStb,
  input  logic              ackStb,
  input  logic [CODE_W-1:0] wdtCode,
  output logic              wdPinN,
  output logic              armed
);

  wdCtl_t ctl;
  logic   expire;
  logic   pulseDone;

  wd_control i_control (
    .clk       (clk),
    .rstN      (rstN),
    .hardClr   (hardClr),
    .armStb    (armStb),
    .ackStb    (ackStb),
    .expire    (expire),
    .pulseDone (pulseDone),
    .ctl       (ctl),
    .wdPinN    (wdPinN),
    .armed     (armed)
  );

  wd_datapath #(
    .BASE_CYCLES  (BASE_CYCLES),
    .PULSE_CYCLES (PULSE_CYCLES),
    .CODE_W       (CODE_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .wdtCode   (wdtCode),
    .expire    (expire),
    .pulseDone (pulseDone)
  );

endmodule

// File: tb/test_wd_supervisor.sv
module test_wd_supervisor;

  localparam int BASE  = 32;
  localparam int PULSE = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hardClr = 1'b0;
  logic       armStb = 1'b0;
  logic       ackStb = 1'b0;
  logic [3:0] wdtCode = 4'd0;
  logic       wdPinN;
  logic       armed;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  wd_supervisor #(.BASE_CYCLES(BASE), .PULSE_CYCLES(PULSE), .CODE_W(4)) i_wd_supervisor (
    .clk(clk), .rstN(rstN), .hardClr(hardClr), .armStb(armStb),
    .ackStb(ackStb), .wdtCode(wdtCode), .wdPinN(wdPinN), .armed(armed)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int limitOf(input int code);
    return (code + 1) * BASE;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts negedges until pin is high again (pulse length)
  task automatic measureLow(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!wdPinN && n < 2000);
  endtask

  task automatic expectQuiet(input int n, input string req);
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!wdPinN || armed) lows++;
    end
    check(lows == 0, req, lows, 0);
  endtask

  // arm with code0; at offset ackAt switch code to code1 and optionally ack
  task automatic runCase(input int code0, input bit doAck, input int ackAt,
                         input int code1, input string req);
    int n = 0;
    int exp;
    int len;
    @(negedge clk);
    wdtCode = 4'(code0);
    armStb = 1'b1;
    @(negedge clk);
    armStb = 1'b0;
    check(armed == 1'b1, "R3", armed, 1);
    do begin
      if (n == ackAt - 1) begin
        wdtCode = 4'(code1);
        ackStb = doAck;
      end
      @(negedge clk);
      n++;
      ackStb = 1'b0;
    end while (wdPinN && n < 2000);
    exp = doAck ? ackAt + limitOf(code1) : limitOf(code0);
    check(n == exp, req, n, exp);
    check(armed == 1'b0, "R6", armed, 0);
    measureLow(len);
    check(len == PULSE, "R5", len, PULSE);
    expectQuiet(3 * BASE, "R6");
  endtask

  initial begin
    int n;
    int c0;
    int c1;
    int at;
    bit ak;
    void'($urandom(32'd1234));

    // power-on
    repeat (4) @(negedge clk);
    check(wdPinN == 1'b0, "R1", wdPinN, 0);
    check(armed == 1'b0, "R1", armed, 0);
    rstN = 1'b1;
    measureLow(n);
    check(n == PULSE, "R1", n, PULSE);

    // dormant after power-on
    expectQuiet(600, "R2");

    // acknowledges while dormant
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); ackStb = 1'b1;
      @(negedge clk); ackStb = 1'b0;
    end
    expectQuiet(600, "R7");

    // directed: plain timeouts at code extremes
    runCase(0, 1'b0, 1, 0, "R3");
    runCase(15, 1'b0, 1, 15, "R3");
    // ack exactly on expiry edge wins
    runCase(2, 1'b1, limitOf(2), 1, "R4");
    // code change without ack leaves limit alone
    runCase(1, 1'b0, 10, 9, "R8");

    // random mix
    for (int it = 0; it < 24; it++) begin
      c0 = int'($urandom_range(0, 15));
      c1 = int'($urandom_range(0, 15));
      at = int'($urandom_range(1, limitOf(c0)));
      ak = 1'($urandom_range(0, 1));
      runCase(c0, ak, at, c1, ak ? "R4" : "R8");
    end

    // hard clear while counting
    @(negedge clk);
    wdtCode = 4'd3;
    armStb = 1'b1;
    @(negedge clk);
    armStb = 1'b0;
    repeat (50) @(negedge clk);
    hardClr = 1'b1;
    ackStb = 1'b1;
    armStb = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(wdPinN == 1'b1 && armed == 1'b0, "R9", {wdPinN, armed}, 2);
    end
    hardClr = 1'b0;
    ackStb = 1'b0;
    armStb = 1'b0;
    expectQuiet(600, "R9");

    // hard clear during pulse
    @(negedge clk);
    wdtCode = 4'd0;
    armStb = 1'b1;
    @(negedge clk);
    armStb = 1'b0;
    repeat (BASE) @(negedge clk);
    check(wdPinN == 1'b0, "R3", wdPinN, 0);
    hardClr = 1'b1;
    @(negedge clk);
    hardClr = 1'b0;
    check(wdPinN == 1'b1, "R9", wdPinN, 1);
    expectQuiet(200, "R9");

    // arming during pulse is ignored
    @(negedge clk);
    wdtCode = 4'd0;
    armStb = 1'b1;
    @(negedge clk);
    armStb = 1'b0;
    repeat (BASE + 3) @(negedge clk);
    check(wdPinN == 1'b0, "R5", wdPinN, 0);
    armStb = 1'b1;
    @(negedge clk);
    armStb = 1'b0;
    measureLow(n);
    check(armed == 1'b0, "R10", armed, 0);
    expectQuiet(300, "R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule